// File: doc/BRIEF.md
# Debug Register Power-Down Access Gate

This block arbitrates debug register accesses from three requesters: an external debugger port, a memory-mapped software port and a coprocessor-style software port. The register space it serves is split into two parts. One part lives in an always-on debug domain and holds a status register and two lock bits. The other part lives in a switchable core domain, and its contents are lost when core power drops. A power-good input reports the core supply state to the gate.

The gate keeps a sticky power-loss flag. The flag is set whenever core power is absent. It is cleared only by a read of the status register made while core power is present, and that read returns the flag value from before the clear. Until the clear happens, every core-domain access gets an error response. As a result, a debugger that never polled during the outage still learns that power was lost. A software-enable input lets the external debugger stop software requesters from changing any register.

Top module: `dbg_pwr_gate`

## Requirements
- R1: Port 0 (external) has priority over port 1 (memory-mapped), and port 1 over port 2 (coprocessor). At most one `req_ready` bit is high per cycle, and only the granted port sees ready.
- R2: An accepted request gets exactly one response, in the next cycle. The response is signalled by the `rsp_valid` bit of the same port.
- R3: Address bit AW-1 = 0 selects the debug domain. Offset 0 is the status register: bit 0 is the live power-good state and bit 1 is the sticky flag. The sticky flag is 1 in every cycle after one in which `pwr_good` was low.
- R4: A status read taken while `pwr_good` is high returns the flag as it was before the read, then clears it. A status read while power is low leaves the flag at 1.
- R5: If power drops in the same cycle as a clearing status read, the flag ends at 1.
- R6: A core-domain access (address bit AW-1 = 1) made while power is low or the flag is 1 returns `rsp_err`=1 with read data 0, and a write in that case changes nothing.
- R7: Port 2 is never granted while `pwr_good` is low. Once power is back, it is granted again.
- R8: Accesses to debug-domain registers never return an error, whatever the power state.
- R9: The software lock (offset 1, bit 0) and the OS lock (offset 2, bit 0) keep their values across core power loss. Only `rst_n` resets them to 0.
- R10: While `sw_en` is low, writes from port 1 and port 2 are accepted but have no effect. Writes from port 0 still apply.
- R11: Core-domain register contents read as 0 after a power loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Debug-domain / power-on reset, active low |
| pwr_good | input | 1 | Core domain powered |
| sw_en | input | 1 | Software writes allowed when high |
| req_valid | input | 3 | Request valid, one bit per port |
| req_we | input | 3 | Write flag, one bit per port |
| req_addr | input | 3*AW | Address, AW bits per port |
| req_wdata | input | 3*DW | Write data, DW bits per port |
| req_ready | output | 3 | Grant / accept, one bit per port |
| rsp_valid | output | 3 | Response valid, one bit per port |
| rsp_rdata | output | DW | Response read data |
| rsp_err | output | 1 | Response error flag |

## Verification
If the sticky flag holds the wrong value, it shows up in the very next response. A core-domain access then errors when it should not, or succeeds when it should not, and a status read returns the wrong bit 1. A lock or core register with bad contents is seen on the first read that follows. The bench therefore reads state back through the ports right after each stimulus: power loss, a clearing read, a same-cycle conflict, a blocked write. A grant that goes wrong is caught in the same cycle, because ready and response valid are sampled every cycle.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
    localparam int NPORT  = 3;
    localparam int P_EXT  = 0;
    localparam int P_MEM  = 1;
    localparam int P_CP   = 2;
    localparam int OFF_STATUS = 0;
    localparam int OFF_SWLOCK = 1;
    localparam int OFF_OSLOCK = 2;
endpackage

// File: rtl/dbg_gate_arb.sv
module dbg_gate_arb #(
    parameter int NP = 3,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic [NP-1:0] valid,
    input  logic [NP-1:0] blocked,
    output logic [NP-1:0] grant,
    output logic [IW-1:0] gidx
);
    logic [NP-1:0] elig;
    assign elig = valid & ~blocked;

    for (genvar i = 0; i < NP; i++) begin : g_pri
        if (i == 0) begin : g_top
            assign grant[i] = elig[i];
        end else begin : g_low
            assign grant[i] = elig[i] & ~(|elig[i-1:0]);
        end
    end

    always_comb begin
        gidx = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (elig[i]) gidx = IW'(i);
        end
    end
endmodule

// File: rtl/dbg_gate_pwr.sv
module dbg_gate_pwr (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic clr_rd,
    output logic sticky_q
);
    typedef struct packed {
        logic sticky;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwr_good)
            st_d.sticky = 1'b1;
        else if (clr_rd)
            st_d.sticky = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sticky_q = st_q.sticky;

    // R3, R5: a cycle without power always leaves the flag set
    a_r3_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> sticky_q);
    // R4: a flag that is set survives while no clearing read is taken
    a_r4_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q && !clr_rd) |=> sticky_q);
endmodule

// File: rtl/dbg_gate_regs.sv
module dbg_gate_regs #(
    parameter int AW = 4,
    parameter int DW = 32,
    localparam int IXW   = AW - 1,
    localparam int NCORE = 1 << IXW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          sw_port,
    input  logic          sw_en,
    input  logic          pwr_good,
    input  logic          sticky,
    output logic [DW-1:0] rdata,
    output logic          err
);
    import dbg_gate_pkg::*;

    typedef struct packed {
        logic                      swlock;
        logic                      oslock;
        logic [NCORE-1:0][DW-1:0]  core;
    } rst_t;

    rst_t st_d, st_q;
    logic           is_core, core_bad, wr_ok;
    logic [IXW-1:0] idx;

    always_comb begin
        is_core  = addr[AW-1];
        idx      = addr[IXW-1:0];
        core_bad = !pwr_good || sticky;
        wr_ok    = acc && we && !(sw_port && !sw_en);
        err      = acc && is_core && core_bad;

        rdata = '0;
        if (is_core) begin
            if (!core_bad) rdata = st_q.core[idx];
        end else begin
            case (int'(idx))
                OFF_STATUS: rdata = DW'({sticky, pwr_good});
                OFF_SWLOCK: rdata = DW'(st_q.swlock);
                OFF_OSLOCK: rdata = DW'(st_q.oslock);
                default:    rdata = '0;
            endcase
        end

        st_d = st_q;
        if (wr_ok && !is_core) begin
            if (int'(idx) == OFF_SWLOCK) st_d.swlock = wdata[0];
            if (int'(idx) == OFF_OSLOCK) st_d.oslock = wdata[0];
        end
        if (wr_ok && is_core && !core_bad) st_d.core[idx] = wdata;
        if (!pwr_good) st_d.core = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: locks change only through an accepted debug-domain write
    a_r9_locks_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && we && !is_core) |=> ($stable(st_q.swlock) && $stable(st_q.oslock)));
    // R10: blocked software write leaves locks untouched
    a_r10_sw_block: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && we && sw_port && !sw_en) |=> ($stable(st_q.swlock) && $stable(st_q.oslock)));
    // R11: core contents lost while unpowered
    a_r11_core_lost: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (st_q.core == '0));
endmodule

// File: rtl/dbg_pwr_gate.sv
module dbg_pwr_gate #(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_good,
    input  logic            sw_en,
    input  logic [2:0]      req_valid,
    input  logic [2:0]      req_we,
    input  logic [3*AW-1:0] req_addr,
    input  logic [3*DW-1:0] req_wdata,
    output logic [2:0]      req_ready,
    output logic [2:0]      rsp_valid,
    output logic [DW-1:0]   rsp_rdata,
    output logic            rsp_err
);
    import dbg_gate_pkg::*;

    localparam int IW = $clog2(NPORT);

    typedef struct packed {
        logic [NPORT-1:0] vld;
        logic [DW-1:0]    data;
        logic             err;
    } rsp_t;

    rsp_t           rs_d, rs_q;
    logic [NPORT-1:0] blocked, grant;
    logic [IW-1:0]  gidx;
    logic           acc, sel_we, sw_port, clr_rd, sticky, r_err;
    logic [AW-1:0]  sel_addr;
    logic [DW-1:0]  sel_wdata, r_data;

    always_comb begin
        blocked       = '0;
        blocked[P_CP] = !pwr_good;
    end

    dbg_gate_arb #(.NP(NPORT)) u_arb (
        .valid(req_valid), .blocked(blocked), .grant(grant), .gidx(gidx)
    );

    always_comb begin
        acc       = |grant;
        sel_we    = req_we[gidx];
        sel_addr  = req_addr[gidx*AW +: AW];
        sel_wdata = req_wdata[gidx*DW +: DW];
        sw_port   = (int'(gidx) != P_EXT);
        clr_rd    = acc && !sel_we && !sel_addr[AW-1] && (sel_addr[AW-2:0] == '0);
    end

    dbg_gate_pwr u_pwr (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .clr_rd(clr_rd), .sticky_q(sticky)
    );

    dbg_gate_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc(acc), .we(sel_we), .addr(sel_addr),
        .wdata(sel_wdata), .sw_port(sw_port), .sw_en(sw_en), .pwr_good(pwr_good),
        .sticky(sticky), .rdata(r_data), .err(r_err)
    );

    always_comb begin
        rs_d.vld  = grant;
        rs_d.data = acc ? r_data : '0;
        rs_d.err  = r_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign req_ready = grant;
    assign rsp_valid = rs_q.vld;
    assign rsp_rdata = rs_q.data;
    assign rsp_err   = rs_q.err;

    // R1: a single grant per cycle
    a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));
    // R1: external port never waits while it requests
    a_r1_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[P_EXT] |-> req_ready[P_EXT]);
    // R2: one response in the cycle after acceptance
    a_r2_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |=> ($countones(rsp_valid) == 1));
    // R6: core access while unpowered or flagged errors
    a_r6_core_err: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req_ready) && sel_addr[AW-1] && (!pwr_good || sticky)) |=> rsp_err);
    // R7: coprocessor port held off while unpowered
    a_r7_cp_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> !req_ready[P_CP]);
    // R8: debug-domain accesses never error
    a_r8_dbg_ok: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req_ready) && !sel_addr[AW-1]) |=> !rsp_err);
endmodule

// File: tb/dbg_pwr_gate_bench.sv
`timescale 1ns/1ps
module dbg_pwr_gate_bench;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_STAT = 4'h0, A_SWL = 4'h1, A_OSL = 4'h2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwr_good = 1'b1;
    logic            sw_en = 1'b1;
    logic [2:0]      req_valid = '0;
    logic [2:0]      req_we = '0;
    logic [3*AW-1:0] req_addr = '0;
    logic [3*DW-1:0] req_wdata = '0;
    logic [2:0]      req_ready, rsp_valid;
    logic [DW-1:0]   rsp_rdata;
    logic            rsp_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dbg_pwr_gate #(.AW(AW), .DW(DW)) u_dbg_pwr_gate (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sw_en(sw_en),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one access; response sampled at the negedge after the accepting posedge
    task automatic access(input int p, input bit we, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                          output logic er);
        int waited = 0;
        @(negedge clk);
        req_valid[p] = 1'b1;
        req_we[p] = we;
        req_addr[p*AW +: AW] = a;
        req_wdata[p*DW +: DW] = wd;
        #1;
        while (!req_ready[p] && waited < 20) begin
            @(negedge clk); #1; waited++;
        end
        check(req_ready[p], "R7 request accepted", 64'(req_ready), 64'(3'b1 << p));
        @(posedge clk);
        @(negedge clk);
        req_valid[p] = 1'b0;
        check(rsp_valid == (3'b1 << p), "R2 response on same port next cycle",
              64'(rsp_valid), 64'(3'b1 << p));
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d; logic e;
        check(rsp_valid == 3'b000 && req_ready == 3'b000, "R2 idle after reset",
              64'({req_ready, rsp_valid}), 64'h0);
        access(0, 0, A_STAT, 0, d, e);
        check(d[1:0] == 2'b01 && !e, "R3 status after reset", 64'(d), 64'h1);
        access(0, 0, A_SWL, 0, d, e);
        check(d == 0, "R9 lock reset value", 64'(d), 64'h0);
    endtask

    task automatic t_core_rw();
        logic [DW-1:0] d; logic e;
        access(0, 1, 4'h8 | 4'h3, 32'hA5A5_0001, d, e);
        access(1, 0, 4'h8 | 4'h3, 0, d, e);
        check(d == 32'hA5A5_0001 && !e, "R6 core readback when powered", 64'(d), 64'hA5A50001);
    endtask

    task automatic t_priority();
        @(negedge clk);
        req_valid = 3'b111; req_we = 3'b000; req_addr = {A_SWL, A_OSL, A_STAT};
        #1;
        check(req_ready == 3'b001, "R1 external port first", 64'(req_ready), 64'h1);
        @(negedge clk);
        check(rsp_valid == 3'b001, "R2 external response", 64'(rsp_valid), 64'h1);
        req_valid[0] = 1'b0; #1;
        check(req_ready == 3'b010, "R1 memory-mapped second", 64'(req_ready), 64'h2);
        @(negedge clk);
        req_valid[1] = 1'b0; #1;
        check(req_ready == 3'b100, "R1 coprocessor last", 64'(req_ready), 64'h4);
        @(negedge clk);
        check(rsp_valid == 3'b100, "R2 coprocessor response", 64'(rsp_valid), 64'h4);
        req_valid = 3'b000;
    endtask

    task automatic t_powerdown();
        logic [DW-1:0] d; logic e;
        access(0, 1, A_SWL, 1, d, e);
        access(0, 1, A_OSL, 1, d, e);
        @(negedge clk); pwr_good = 1'b0;
        repeat (2) @(negedge clk);
        access(0, 0, A_STAT, 0, d, e);
        check(d[1:0] == 2'b10, "R3 flag set while off", 64'(d), 64'h2);
        access(0, 0, A_STAT, 0, d, e);
        check(d[1:0] == 2'b10, "R4 read while off keeps flag", 64'(d), 64'h2);
        access(0, 0, 4'hB, 0, d, e);
        check(e && d == 0, "R6 core access while off errors", 64'({e, d}), 64'h1_0000_0000);
        @(negedge clk);
        req_valid[2] = 1'b1; req_we[2] = 1'b0; req_addr[2*AW +: AW] = A_STAT;
        for (int i = 0; i < 5; i++) begin
            #1;
            check(!req_ready[2], "R7 coprocessor held off", 64'(req_ready), 64'h0);
            @(negedge clk);
        end
        req_valid[2] = 1'b0;
        access(1, 0, A_SWL, 0, d, e);
        check(d == 1 && !e, "R8 R9 swlock kept while off, no error", 64'({e, d}), 64'h1);
        access(0, 0, A_OSL, 0, d, e);
        check(d == 1 && !e, "R9 oslock kept while off", 64'({e, d}), 64'h1);
        @(negedge clk); pwr_good = 1'b1;
        @(negedge clk);
        access(1, 0, 4'hB, 0, d, e);
        check(e, "R6 flagged core access errors after power return", 64'(e), 64'h1);
        access(1, 1, 4'hB, 32'h1234, d, e);
        access(0, 0, A_STAT, 0, d, e);
        check(d[1:0] == 2'b11, "R4 clearing read returns old flag", 64'(d), 64'h3);
        access(0, 0, A_STAT, 0, d, e);
        check(d[1:0] == 2'b01, "R4 flag cleared", 64'(d), 64'h1);
        access(2, 0, 4'hB, 0, d, e);
        check(d == 0 && !e, "R11 R6 core content lost, flagged write dropped", 64'({e, d}), 64'h0);
        access(0, 0, 4'h8 | 4'h3, 0, d, e);
        check(d == 0 && !e, "R11 earlier core value lost", 64'(d), 64'h0);
    endtask

    task automatic t_same_cycle();
        logic [DW-1:0] d; logic e;
        @(negedge clk);
        req_valid[0] = 1'b1; req_we[0] = 1'b0; req_addr[0 +: AW] = A_STAT;
        pwr_good = 1'b0;
        @(negedge clk);
        req_valid[0] = 1'b0; pwr_good = 1'b1;
        access(0, 0, A_STAT, 0, d, e);
        check(d[1:1] == 1'b1, "R5 drop wins over clearing read", 64'(d), 64'h3);
        access(0, 0, A_STAT, 0, d, e);
        check(d[1:0] == 2'b01, "R4 later read clears", 64'(d), 64'h1);
    endtask

    task automatic t_sw_en();
        logic [DW-1:0] d; logic e;
        sw_en = 1'b0;
        access(1, 1, A_OSL, 0, d, e);
        access(0, 0, A_OSL, 0, d, e);
        check(d == 1, "R10 blocked software lock write", 64'(d), 64'h1);
        access(2, 1, 4'hA, 32'h33, d, e);
        access(0, 0, 4'hA, 0, d, e);
        check(d == 0, "R10 blocked coprocessor write", 64'(d), 64'h0);
        access(0, 1, 4'hA, 32'h44, d, e);
        access(1, 0, 4'hA, 0, d, e);
        check(d == 32'h44, "R10 external write still applies", 64'(d), 64'h44);
        sw_en = 1'b1;
        access(1, 1, A_OSL, 0, d, e);
        access(0, 0, A_OSL, 0, d, e);
        check(d == 0, "R10 software write applies when enabled", 64'(d), 64'h0);
    endtask

    task automatic t_lock_reset();
        logic [DW-1:0] d; logic e;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(0, 0, A_SWL, 0, d, e);
        check(d == 0, "R9 reset clears lock", 64'(d), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_core_rw();
        t_priority();
        t_powerdown();
        t_same_cycle();
        t_sw_en();
        t_lock_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule